// File: doc/BRIEF.md
# Adaptive Phase Switch Decider

This block decides when a two-arm signalised junction should end its current green phase. It counts the queued cars on each arm: an entry sensor pulse adds a car and an exit sensor pulse removes one. It measures how long the current phase has run, in units of an external tick. It also evaluates a signed linear cost for each arm. When the phase has lasted long enough and the traffic picture says the favoured arm no longer needs the green, it raises a one-cycle switch strobe. A separate light sequencer consumes the strobe.

The cost of arm A is `alpha_a*cnt_a + beta_a - cnt_b`, and the cost of arm B is `alpha_b*cnt_b + beta_b - cnt_a`. The favoured arm is the one that holds the green. Between the phase's minimum and maximum time, that arm gives way in two cases: its cost falls to zero or below, or its queue has stalled (no change for five ticks) while cars wait on the other arm. A left-turn phase has its own bounds and ends purely on time. A pedestrian phase suspends all decisions and restarts the phase clock. Weights, offsets and bounds are sampled while reset is asserted and are held from then on.

The decision engine has four states. `ST_HOLD` waits out the minimum time. `ST_WATCH` evaluates the release rules. `ST_FIRE` drives the strobe for one cycle. `ST_PED` waits while a pedestrian phase is active. Its transitions are:
- HOLD→WATCH when T ≥ min.
- WATCH→FIRE when a release rule holds.
- FIRE→HOLD unconditionally.
- PED→HOLD when the pedestrian indication drops.
- Any state →PED while the pedestrian indication is high.

Top module: `phase_switch_ctrl`

## Requirements
- R1: Each arm's count rises by one on a clock with its entry pulse high and its exit pulse low. It falls by one on a clock with the exit pulse high and the entry pulse low. The counts are visible on `cnt_a` / `cnt_b` from the next cycle.
- R2: A count stays at 0 on an exit pulse and stays at its maximum (all ones, 255 by default) on an entry pulse. Entry and exit pulses in the same cycle leave the count unchanged.
- R3: `fav_arm` selects the favoured arm (0 = arm A, 1 = arm B). In a through phase (`left_phase`=0), once the minimum is met, the strobe is raised when that arm's cost is ≤ 0.
- R4: The phase timer T counts ticks since the phase started. No strobe is raised while T is below the phase minimum (`min_thru` for through phases, `min_left` for left-turn phases).
- R5: In a through phase the strobe is raised once T reaches `max_thru`, whatever the costs and queues.
- R6: In a through phase, the strobe is raised after the favoured count has been unchanged for 5 ticks, but only if the opposing count is nonzero. With the opposing count zero, a stalled queue does not end the phase.
- R7: In a left-turn phase (`left_phase`=1) the strobe is raised only when T reaches `max_left`. Cost and stall rules are ignored.
- R8: The strobe lasts one cycle and appears in the cycle after the edge at which the release rule was seen. T and the stall measure restart from zero after the strobe.
- R9: While `ped_active` is high, no strobe is raised and T restarts. After `ped_active` falls, a new phase begins with T = 0. During reset the strobe is low and both counts are 0.
- R10: The weights, offsets and bounds are taken from the configuration inputs during reset only. Changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is sampled while low |
| tick | input | 1 | One-cycle time-unit pulse |
| enter_a | input | 1 | Arm A entry sensor pulse |
| exit_a | input | 1 | Arm A exit sensor pulse |
| enter_b | input | 1 | Arm B entry sensor pulse |
| exit_b | input | 1 | Arm B exit sensor pulse |
| fav_arm | input | 1 | Arm holding the green (0 = A, 1 = B) |
| left_phase | input | 1 | Current phase is a left-turn phase |
| ped_active | input | 1 | Pedestrian phase in progress |
| cfg_alpha_a | input | AW | Signed weight of arm A |
| cfg_alpha_b | input | AW | Signed weight of arm B |
| cfg_beta_a | input | BW | Signed offset of arm A |
| cfg_beta_b | input | BW | Signed offset of arm B |
| cfg_min_thru | input | TW | Through-phase minimum, ticks |
| cfg_max_thru | input | TW | Through-phase maximum, ticks |
| cfg_min_left | input | TW | Left-turn minimum, ticks |
| cfg_max_left | input | TW | Left-turn maximum, ticks |
| switch_o | output | 1 | One-cycle switch request |
| cnt_a | output | CW | Arm A queue count |
| cnt_b | output | CW | Arm B queue count |

## Verification
The release rules are driven one at a time against a cycle-by-cycle reference model.
- A cost-zero idle phase, and the same with arm B favoured, show the cost rule acting at the minimum time.
- Steady arrivals on the favoured arm keep its cost positive and its queue moving. Only the maximum time can end that phase, so the bench confirms silence before the maximum and one strobe after it.
- A frozen favoured queue with cars opposite, against the same queue with the opposite arm empty, separates the stall rule from the maximum time.
- A left-turn phase, a long pedestrian hold, long saturating pulse trains with simultaneous entry and exit, and configuration changes after reset cover the remaining rules.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_WATCH = 2'd1,
        ST_FIRE  = 2'd2,
        ST_PED   = 2'd3
    } tsw_state_e;

endpackage

// File: rtl/tsw_queue_counter.sv
`timescale 1ns/1ps
module tsw_queue_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_i,
    input  logic          exit_i,
    output logic [CW-1:0] cnt_o,
    output logic          chg_o
);

    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_q;
    logic          up, dn;

    always_comb begin
        up    = enter_i && !exit_i && (cnt_q != CMAX);
        dn    = exit_i && !enter_i && (cnt_q != '0);
        chg_o = up || dn;
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt_q <= '0;
        else if (up) cnt_q <= cnt_q + 1'b1;
        else if (dn) cnt_q <= cnt_q - 1'b1;
    end

    a_r2_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && exit_i) |=> $stable(cnt_q));

    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !enter_i && cnt_q == '0) |=> (cnt_q == '0));

    a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !exit_i && cnt_q == CMAX) |=> (cnt_q == CMAX));

endmodule

// File: rtl/tsw_phase_timer.sv
`timescale 1ns/1ps
module tsw_phase_timer #(
    parameter int TW        = 8,
    parameter int STALL_LIM = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic          fav_chg_i,
    output logic [TW-1:0] t_o,
    output logic          stall_o
);

    localparam int            SW   = $clog2(STALL_LIM + 1);
    localparam logic [TW-1:0] TMAX = '1;
    localparam logic [SW-1:0] SLIM = SW'(STALL_LIM);

    logic [TW-1:0] t_q;
    logic [SW-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        t_q <= '0;
        else if (clear_i)                  t_q <= '0;
        else if (tick_i && t_q != TMAX)    t_q <= t_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        st_q <= '0;
        else if (clear_i || fav_chg_i)     st_q <= '0;
        else if (tick_i && st_q < SLIM)    st_q <= st_q + 1'b1;
    end

    always_comb begin
        t_o     = t_q;
        stall_o = (st_q >= SLIM);
    end

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (t_q == '0 && st_q == '0));

    a_r6_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q <= SLIM);

    a_r4_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(t_q));

endmodule

// File: rtl/tsw_cost_eval.sv
`timescale 1ns/1ps
module tsw_cost_eval #(
    parameter int CW = 8,
    parameter int AW = 6,
    parameter int BW = 10,
    parameter int FW = 17
) (
    input  logic        [1:0][CW-1:0] n_i,
    input  logic signed [AW-1:0]      alpha_i [2],
    input  logic signed [BW-1:0]      beta_i  [2],
    output logic signed [FW-1:0]      cost_o  [2]
);

    for (genvar g = 0; g < 2; g++) begin : g_arm
        logic signed [FW-1:0] own_s, opp_s, al_s, be_s;
        always_comb begin
            own_s     = FW'({1'b0, n_i[g]});
            opp_s     = FW'({1'b0, n_i[1-g]});
            al_s      = FW'(alpha_i[g]);
            be_s      = FW'(beta_i[g]);
            cost_o[g] = al_s * own_s + be_s - opp_s;
        end
    end

endmodule

// File: rtl/tsw_switch_fsm.sv
`timescale 1ns/1ps
module tsw_switch_fsm
    import tsw_pkg::*;
#(
    parameter int TW = 8,
    parameter int FW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ped_i,
    input  logic                 left_i,
    input  logic [TW-1:0]        t_i,
    input  logic [TW-1:0]        min_i,
    input  logic [TW-1:0]        max_i,
    input  logic signed [FW-1:0] cost_i,
    input  logic                 stall_i,
    input  logic                 opp_nz_i,
    output tsw_state_e           state_o,
    output logic                 switch_o
);

    tsw_state_e state_q, state_d;
    logic       at_max, cost_low, stall_rel, release_ok;

    always_comb begin
        at_max     = (t_i >= max_i);
        cost_low   = cost_i[FW-1] || (cost_i == '0);
        stall_rel  = stall_i && opp_nz_i;
        release_ok = left_i ? at_max : (at_max || cost_low || stall_rel);
    end

    always_comb begin
        state_d = state_q;
        if (ped_i) begin
            state_d = ST_PED;
        end else begin
            unique case (state_q)
                ST_HOLD:  if (t_i >= min_i) state_d = ST_WATCH;
                ST_WATCH: if (release_ok)   state_d = ST_FIRE;
                ST_FIRE:                    state_d = ST_HOLD;
                ST_PED:                     state_d = ST_HOLD;
                default:                    state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o  = state_q;
        switch_o = (state_q == ST_FIRE) && !ped_i;
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |=> !switch_o);

    a_r9_ped_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ped_i |=> (state_q == ST_PED));

    a_r9_ped_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PED && !ped_i) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/phase_switch_ctrl.sv
`timescale 1ns/1ps
module phase_switch_ctrl
    import tsw_pkg::*;
#(
    parameter int CW        = 8,
    parameter int TW        = 8,
    parameter int AW        = 6,
    parameter int BW        = 10,
    parameter int STALL_LIM = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 enter_a,
    input  logic                 exit_a,
    input  logic                 enter_b,
    input  logic                 exit_b,
    input  logic                 fav_arm,
    input  logic                 left_phase,
    input  logic                 ped_active,
    input  logic signed [AW-1:0] cfg_alpha_a,
    input  logic signed [AW-1:0] cfg_alpha_b,
    input  logic signed [BW-1:0] cfg_beta_a,
    input  logic signed [BW-1:0] cfg_beta_b,
    input  logic [TW-1:0]        cfg_min_thru,
    input  logic [TW-1:0]        cfg_max_thru,
    input  logic [TW-1:0]        cfg_min_left,
    input  logic [TW-1:0]        cfg_max_left,
    output logic                 switch_o,
    output logic [CW-1:0]        cnt_a,
    output logic [CW-1:0]        cnt_b
);

    localparam int FW = ((CW + AW > BW) ? (CW + AW) : BW) + 3;

    // configuration held from reset
    logic signed [AW-1:0] alpha_q [2];
    logic signed [BW-1:0] beta_q  [2];
    logic [TW-1:0]        min_thru_q, max_thru_q, min_left_q, max_left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alpha_q[0] <= cfg_alpha_a;
            alpha_q[1] <= cfg_alpha_b;
            beta_q[0]  <= cfg_beta_a;
            beta_q[1]  <= cfg_beta_b;
            min_thru_q <= cfg_min_thru;
            max_thru_q <= cfg_max_thru;
            min_left_q <= cfg_min_left;
            max_left_q <= cfg_max_left;
        end
    end

    // queue counters
    logic [1:0]         enter_v, exit_v, chg_v;
    logic [1:0][CW-1:0] n_v;

    assign enter_v = {enter_b, enter_a};
    assign exit_v  = {exit_b, exit_a};

    for (genvar g = 0; g < 2; g++) begin : g_queue
        tsw_queue_counter #(.CW(CW)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .enter_i (enter_v[g]),
            .exit_i  (exit_v[g]),
            .cnt_o   (n_v[g]),
            .chg_o   (chg_v[g])
        );
    end

    assign cnt_a = n_v[0];
    assign cnt_b = n_v[1];

    // cost functions
    logic signed [FW-1:0] cost_v [2];

    tsw_cost_eval #(.CW(CW), .AW(AW), .BW(BW), .FW(FW)) u_cost (
        .n_i     (n_v),
        .alpha_i (alpha_q),
        .beta_i  (beta_q),
        .cost_o  (cost_v)
    );

    // phase timer and decision
    tsw_state_e           state;
    logic [TW-1:0]        t_now, min_sel, max_sel;
    logic                 stall, fav_chg, opp_nz, tmr_clear;
    logic signed [FW-1:0] cost_fav;

    always_comb begin
        fav_chg   = fav_arm ? chg_v[1] : chg_v[0];
        opp_nz    = fav_arm ? (n_v[0] != '0) : (n_v[1] != '0);
        cost_fav  = fav_arm ? cost_v[1] : cost_v[0];
        min_sel   = left_phase ? min_left_q : min_thru_q;
        max_sel   = left_phase ? max_left_q : max_thru_q;
        tmr_clear = (state == ST_FIRE) || (state == ST_PED) || ped_active;
    end

    tsw_phase_timer #(.TW(TW), .STALL_LIM(STALL_LIM)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .clear_i   (tmr_clear),
        .fav_chg_i (fav_chg),
        .t_o       (t_now),
        .stall_o   (stall)
    );

    tsw_switch_fsm #(.TW(TW), .FW(FW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ped_i    (ped_active),
        .left_i   (left_phase),
        .t_i      (t_now),
        .min_i    (min_sel),
        .max_i    (max_sel),
        .cost_i   (cost_fav),
        .stall_i  (stall),
        .opp_nz_i (opp_nz),
        .state_o  (state),
        .switch_o (switch_o)
    );

    a_r4_min_met: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |-> (t_now >= min_sel));

    a_r8_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |=> (t_now == '0));

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(min_thru_q) && $stable(max_thru_q)
                  && $stable(min_left_q) && $stable(max_left_q)));

endmodule

// File: tb/phase_switch_ctrl_tb.sv
`timescale 1ns/1ps
module phase_switch_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic enter_a = 0, exit_a = 0, enter_b = 0, exit_b = 0;
    logic fav_arm = 0, left_phase = 0, ped_active = 0;
    logic signed [5:0] cfg_alpha_a, cfg_alpha_b;
    logic signed [9:0] cfg_beta_a, cfg_beta_b;
    logic [7:0] cfg_min_thru, cfg_max_thru, cfg_min_left, cfg_max_left;
    logic switch_o;
    logic [7:0] cnt_a, cnt_b;

    always #2.5 clk = ~clk;

    phase_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .enter_a(enter_a), .exit_a(exit_a), .enter_b(enter_b), .exit_b(exit_b),
        .fav_arm(fav_arm), .left_phase(left_phase), .ped_active(ped_active),
        .cfg_alpha_a(cfg_alpha_a), .cfg_alpha_b(cfg_alpha_b),
        .cfg_beta_a(cfg_beta_a), .cfg_beta_b(cfg_beta_b),
        .cfg_min_thru(cfg_min_thru), .cfg_max_thru(cfg_max_thru),
        .cfg_min_left(cfg_min_left), .cfg_max_left(cfg_max_left),
        .switch_o(switch_o), .cnt_a(cnt_a), .cnt_b(cnt_b)
    );

    int    n_run = 0, n_fail = 0;
    string tag = "R9";
    bit    done = 0;

    // reference model state: 0 hold, 1 watch, 2 fire, 3 pedestrian
    int m_na, m_nb, m_t, m_st, m_state;
    int c_aa, c_ab, c_ba, c_bb, c_mint, c_maxt, c_minl, c_maxl;
    int win_dut = 0, win_mod = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_na = 0; m_nb = 0; m_t = 0; m_st = 0; m_state = 0;
            c_aa = int'(cfg_alpha_a); c_ab = int'(cfg_alpha_b);
            c_ba = int'(cfg_beta_a);  c_bb = int'(cfg_beta_b);
            c_mint = int'(cfg_min_thru); c_maxt = int'(cfg_max_thru);
            c_minl = int'(cfg_min_left); c_maxl = int'(cfg_max_left);
        end else begin
            int na2, nb2, fav, opp, mn, mx, nxt;
            bit chg_a, chg_b, fchg, clr, rel;
            na2 = m_na; nb2 = m_nb;
            if (enter_a && !exit_a && m_na < 255) na2 = m_na + 1;
            if (exit_a && !enter_a && m_na > 0)   na2 = m_na - 1;
            if (enter_b && !exit_b && m_nb < 255) nb2 = m_nb + 1;
            if (exit_b && !enter_b && m_nb > 0)   nb2 = m_nb - 1;
            chg_a = (na2 != m_na); chg_b = (nb2 != m_nb);
            fchg  = fav_arm ? chg_b : chg_a;
            fav   = fav_arm ? (c_ab * m_nb + c_bb - m_na) : (c_aa * m_na + c_ba - m_nb);
            opp   = fav_arm ? m_na : m_nb;
            mn    = left_phase ? c_minl : c_mint;
            mx    = left_phase ? c_maxl : c_maxt;
            if (left_phase) rel = (m_t >= mx);
            else            rel = (m_t >= mx) || (fav <= 0) || (m_st >= 5 && opp != 0);
            clr = (m_state == 2) || (m_state == 3) || ped_active;
            if (ped_active) nxt = 3;
            else case (m_state)
                0: nxt = (m_t >= mn) ? 1 : 0;
                1: nxt = rel ? 2 : 1;
                default: nxt = 0;
            endcase
            if (clr) m_t = 0; else if (tick && m_t < 255) m_t = m_t + 1;
            if (clr || fchg) m_st = 0; else if (tick && m_st < 5) m_st = m_st + 1;
            m_state = nxt; m_na = na2; m_nb = nb2;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_sw;
            exp_sw = (m_state == 2) && !ped_active;
            n_run++;
            if (switch_o !== exp_sw) begin
                n_fail++;
                $display("FAIL %s switch_o got %0b expected %0b at %0t", tag, switch_o, exp_sw, $time);
            end
            n_run++;
            if (int'(cnt_a) != m_na || int'(cnt_b) != m_nb) begin
                n_fail++;
                $display("FAIL R1 counts got %0d/%0d expected %0d/%0d", cnt_a, cnt_b, m_na, m_nb);
            end
            if (switch_o) win_dut++;
            if (exp_sw)   win_mod++;
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic open_win(input string req);
        tag = req; win_dut = 0; win_mod = 0;
    endtask

    // expect_any: 1 = at least one strobe, 0 = none at all
    task automatic close_win(input string req, input bit expect_any);
        check(req, win_dut == win_mod, win_dut, win_mod);
        if (expect_any) check(req, win_mod > 0, win_mod, 1);
        else            check(req, win_mod == 0, win_mod, 0);
    endtask

    task automatic ped_then(input bit fa, input bit lp);
        @(negedge clk) ped_active = 1;
        cycles(3);
        fav_arm = fa; left_phase = lp;
        cycles(1);
        ped_active = 0;
    endtask

    task automatic pulse(ref logic s, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) s = 1;
            @(negedge clk) s = 0;
            cycles(gap);
        end
    endtask

    always @(negedge clk) tick = rst_n;

    initial begin
        cfg_alpha_a = 6'sd1;  cfg_alpha_b = 6'sd2;
        cfg_beta_a  = 10'sd0; cfg_beta_b  = -10'sd1;
        cfg_min_thru = 8'd4;  cfg_max_thru = 8'd30;
        cfg_min_left = 8'd3;  cfg_max_left = 8'd12;
        cycles(3);
        check("R9", switch_o == 0, switch_o, 0);
        check("R9", cnt_a == 0 && cnt_b == 0, cnt_a + cnt_b, 0);
        @(negedge clk) rst_n = 1;
        // R10: later changes must be ignored
        cfg_alpha_a = -6'sd5; cfg_beta_a = -10'sd100; cfg_min_thru = 8'd0;
        cfg_max_thru = 8'd2;  cfg_max_left = 8'd1;

        // R3: arm A idle, cost 0, releases at min
        open_win("R3"); cycles(14); close_win("R3", 1);

        // R5/R4: steady arrivals on A keep cost positive and queue moving
        ped_then(0, 0);
        open_win("R4"); pulse(enter_a, 12, 0); close_win("R4", 0);
        open_win("R5"); pulse(enter_a, 8, 0);  close_win("R5", 1);

        // R6: frozen A queue with cars on B
        ped_then(0, 0);
        pulse(enter_b, 3, 0);
        open_win("R6"); cycles(15); close_win("R6", 1);
        // R6: same but B empty -> only max ends it
        ped_then(0, 0);
        pulse(exit_b, 3, 0);
        open_win("R6"); cycles(20); close_win("R6", 0);
        open_win("R5"); cycles(15); close_win("R5", 1);

        // R7: left phase, arm B favoured with negative cost and stalled queue
        ped_then(1, 1);
        open_win("R7"); cycles(10); close_win("R7", 0);
        open_win("R7"); cycles(10); close_win("R7", 1);
        // R8: strobe count over two left periods stays bounded by timing
        open_win("R8"); cycles(16); close_win("R8", 1);
        check("R8", win_mod <= 2, win_mod, 2);

        // R9: long pedestrian hold while release rules are true
        @(negedge clk) ped_active = 1;
        open_win("R9"); cycles(20); close_win("R9", 0);
        fav_arm = 1; left_phase = 0;
        @(negedge clk) ped_active = 0;
        open_win("R3"); cycles(10); close_win("R3", 1);

        // R2: floor, ceiling, simultaneous pulses
        ped_then(0, 0);
        tag = "R2";
        @(negedge clk) exit_a = 1;
        cycles(40);
        exit_a = 0;
        cycles(1);
        check("R2", cnt_a == 0, cnt_a, 0);
        enter_b = 1;
        cycles(262);
        enter_b = 0;
        cycles(1);
        check("R2", cnt_b == 255, cnt_b, 255);
        enter_a = 1; exit_a = 1; enter_b = 1; exit_b = 1;
        cycles(5);
        enter_a = 0; exit_a = 0; enter_b = 0; exit_b = 0;
        cycles(1);
        check("R2", cnt_a == 0 && cnt_b == 255, cnt_b, 255);
        // R1: single steps
        pulse(enter_a, 3, 1);
        check("R1", cnt_a == 3, cnt_a, 3);
        pulse(exit_b, 2, 1);
        check("R1", cnt_b == 253, cnt_b, 253);
        // R10: captured min 4 still in force
        ped_then(0, 0);
        open_win("R10"); cycles(3); close_win("R10", 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule